// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital side of a successive-approximation analog-to-digital converter. Writing a channel code starts a conversion. The block then runs a binary search. On every clock it presents a trial code on `dac_code` to an external DAC and comparator, and it reads back the one-bit decision on `cmp_in`. The search resolves 12 raw bits in the 12-bit and 10-bit modes and 9 raw bits in the 8-bit mode. In the 10-bit and 8-bit modes the raw code is rounded to the target width, not truncated.

The final value is right-justified into `result` and `done_flag` is set. The interrupt line follows the flag when `irq_en` is high. An optional automatic compare can hold back a result that fails a threshold test. A failing result neither updates `result` nor sets the flag.

A channel code of all ones does not select an input. It turns the converter off: it starts nothing and stops any conversion in flight. Reading the result clears the flag.

Top module: `sar_conv_ctrl`

## Requirements
- R1: After reset, `busy`, `done_flag`, `irq`, `result` and `dac_code` are all 0.
- R2: A `chan_wr` pulse with a `chan_sel` value other than all ones starts a conversion. A `chan_wr` with `chan_sel` all ones starts nothing and stops a running conversion. In that case `busy` is 0 on the next cycle, and `result` and `done_flag` keep their values.
- R3: The search is MSB first. The first trial code is 0x800. Each cycle the trial bit is kept when `cmp_in` is 1 (input at or above the trial level) and cleared otherwise. The result is written, and `busy` drops, 12 clocks after the start edge in modes 1 and 2/3, and 9 clocks after it in mode 0.
- R4: While no conversion is running, `dac_code` stays at 0.
- R5: With `res_mode` 2 or 3 (12-bit), `result` equals the 12-bit raw code.
- R6: With `res_mode` 1 (10-bit), `result` is min((raw + 2) >> 2, 1023) and bits 11:10 are 0.
- R7: With `res_mode` 0 (8-bit), the 9 raw bits are trialled on `dac_code[11:3]` with bits 2:0 held at 0. `result` is min((raw9 + 1) >> 1, 255) and bits 11:8 are 0.
- R8: Writing a result sets `done_flag`. `irq` is high exactly when `done_flag` and `irq_en` are both 1.
- R9: A `res_rd` pulse clears `done_flag` on the next cycle. Starting a new conversion also clears it.
- R10: With `cmp_en` 1, a result passes when it is >= `cmp_thr` (`cmp_gt` 1) or < `cmp_thr` (`cmp_gt` 0). This holds in every mode. A failing result leaves `result` unchanged and does not set `done_flag`.
- R11: A valid `chan_wr` during a conversion discards it and restarts the search from 0x800. The new result follows the full conversion length after the restart edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_wr | input | 1 | Channel write strobe, one cycle |
| chan_sel | input | CH_W | Channel code; all ones disables the converter |
| res_mode | input | 2 | 0 = 8-bit, 1 = 10-bit, 2 or 3 = 12-bit |
| irq_en | input | 1 | Conversion-complete interrupt enable |
| cmp_en | input | 1 | Automatic compare enable |
| cmp_gt | input | 1 | Compare sense: 1 = pass if >= threshold, 0 = pass if < threshold |
| cmp_thr | input | 12 | Compare threshold, right-justified |
| cmp_in | input | 1 | Comparator decision, 1 = input at or above trial level |
| res_rd | input | 1 | Result read strobe, clears the flag |
| dac_code | output | 12 | Trial code for the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 12 | Right-justified conversion result |
| done_flag | output | 1 | Conversion-complete flag |
| irq | output | 1 | Conversion-complete interrupt |

## Verification
The assertions assume that `res_mode` is held steady from the start strobe to the end of the search. They also assume that `cmp_in` is a settled function of the present `dac_code`. The stimulus meets both assumptions. It changes the mode only while the converter is idle. It models the comparator combinationally as an ideal comparison of a hidden 12-bit input against `dac_code`, and it changes that input only between conversions or at a restart strobe. Strobes are single-cycle and are driven half a cycle away from the sampling edge.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W     = 12;
  localparam int MID_W     = RES_W - 2;
  localparam int LOW_W     = RES_W - 4;
  localparam int LOW_RAW_W = LOW_W + 1;
  localparam int STEP_W    = $clog2(RES_W + 1);

  typedef enum logic [1:0] {
    RES_LOW      = 2'd0,
    RES_MID      = 2'd1,
    RES_FULL     = 2'd2,
    RES_FULL_ALT = 2'd3
  } res_mode_e;

  // number of raw bits the search resolves for a mode
  function automatic logic [STEP_W-1:0] raw_bits(res_mode_e m);
    return (m == RES_LOW) ? STEP_W'(LOW_RAW_W) : STEP_W'(RES_W);
  endfunction

  // left-aligned raw code -> right-justified rounded result, saturating
  function automatic logic [RES_W-1:0] round_raw(logic [RES_W-1:0] raw, res_mode_e m);
    logic [MID_W:0] mid_sum;
    logic [LOW_W:0] low_sum;
    mid_sum = {1'b0, raw[RES_W-1:2]} + {{MID_W{1'b0}}, raw[1]};
    low_sum = {1'b0, raw[RES_W-1:4]} + {{LOW_W{1'b0}}, raw[3]};
    case (m)
      RES_MID: return mid_sum[MID_W] ? {{(RES_W-MID_W){1'b0}}, {MID_W{1'b1}}}
                                     : {{(RES_W-MID_W){1'b0}}, mid_sum[MID_W-1:0]};
      RES_LOW: return low_sum[LOW_W] ? {{(RES_W-LOW_W){1'b0}}, {LOW_W{1'b1}}}
                                     : {{(RES_W-LOW_W){1'b0}}, low_sum[LOW_W-1:0]};
      default: return raw;
    endcase
  endfunction

  function automatic logic cmp_pass(logic [RES_W-1:0] val, logic [RES_W-1:0] thr, logic gt);
    return gt ? (val >= thr) : (val < thr);
  endfunction
endpackage

// File: rtl/sar_search.sv
module sar_search
  import sar_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  res_mode_e        mode,
  input  logic             cmp_in,
  output logic             busy,
  output logic [RES_W-1:0] dac_code,
  output logic             conv_end,
  output logic [RES_W-1:0] raw_code,
  output res_mode_e        conv_mode
);
  localparam logic [RES_W-1:0] MSB = {1'b1, {(RES_W-1){1'b0}}};

  logic              busy_q;
  logic [STEP_W-1:0] step_q;
  logic [STEP_W-1:0] nbits_q;
  logic [RES_W-1:0]  acc_q;
  res_mode_e         mode_q;

  logic [RES_W-1:0] trial_mask;
  logic [RES_W-1:0] trial;
  logic [RES_W-1:0] decided;
  logic             last_step;

  assign trial_mask = MSB >> step_q;
  assign trial      = acc_q | trial_mask;
  assign decided    = cmp_in ? trial : acc_q;
  assign last_step  = (step_q == nbits_q - STEP_W'(1));

  assign busy      = busy_q;
  assign dac_code  = busy_q ? trial : '0;
  assign conv_end  = busy_q && last_step && !stop;
  assign raw_code  = decided;
  assign conv_mode = mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      step_q  <= '0;
      nbits_q <= STEP_W'(RES_W);
      acc_q   <= '0;
      mode_q  <= RES_FULL;
    end else if (start) begin
      busy_q  <= 1'b1;
      step_q  <= '0;
      acc_q   <= '0;
      mode_q  <= mode;
      nbits_q <= raw_bits(mode);
    end else if (stop) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      acc_q <= decided;
      if (last_step) busy_q <= 1'b0;
      else           step_q <= step_q + STEP_W'(1);
    end
  end

  // R3: every start or restart presents the midscale trial first
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (dac_code == MSB));

  // R4: no trial activity while idle
  a_r4_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !start) |=> (dac_code == '0));
endmodule

// File: rtl/sar_result.sv
module sar_result
  import sar_pkg::*;
(
  input  logic [RES_W-1:0] raw_code,
  input  res_mode_e        mode,
  input  logic             cmp_en,
  input  logic             cmp_gt,
  input  logic [RES_W-1:0] cmp_thr,
  output logic [RES_W-1:0] res_val,
  output logic             accept
);
  assign res_val = round_raw(raw_code, mode);
  assign accept  = !cmp_en || cmp_pass(res_val, cmp_thr, cmp_gt);
endmodule

// File: rtl/sar_conv_ctrl.sv
module sar_conv_ctrl
  import sar_pkg::*;
#(
  parameter int CH_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chan_wr,
  input  logic [CH_W-1:0]  chan_sel,
  input  logic [1:0]       res_mode,
  input  logic             irq_en,
  input  logic             cmp_en,
  input  logic             cmp_gt,
  input  logic [RES_W-1:0] cmp_thr,
  input  logic             cmp_in,
  input  logic             res_rd,
  output logic [RES_W-1:0] dac_code,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             done_flag,
  output logic             irq
);
  localparam logic [CH_W-1:0] CH_OFF = {CH_W{1'b1}};

  logic             start_ev;
  logic             stop_ev;
  logic             conv_end;
  logic             accept;
  logic             wr_en;
  logic [RES_W-1:0] raw_code;
  logic [RES_W-1:0] res_val;
  res_mode_e        conv_mode;
  logic [RES_W-1:0] result_q;
  logic             flag_q;

  assign start_ev = chan_wr && (chan_sel != CH_OFF);
  assign stop_ev  = chan_wr;

  sar_search u_search (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_ev),
    .stop      (stop_ev),
    .mode      (res_mode_e'(res_mode)),
    .cmp_in    (cmp_in),
    .busy      (busy),
    .dac_code  (dac_code),
    .conv_end  (conv_end),
    .raw_code  (raw_code),
    .conv_mode (conv_mode)
  );

  sar_result u_result (
    .raw_code (raw_code),
    .mode     (conv_mode),
    .cmp_en   (cmp_en),
    .cmp_gt   (cmp_gt),
    .cmp_thr  (cmp_thr),
    .res_val  (res_val),
    .accept   (accept)
  );

  assign wr_en = conv_end && accept;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_q <= '0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_en) result_q <= res_val;
      if (start_ev)    flag_q <= 1'b0;
      else if (wr_en)  flag_q <= 1'b1;
      else if (res_rd) flag_q <= 1'b0;
    end
  end

  assign result    = result_q;
  assign done_flag = flag_q;
  assign irq       = flag_q && irq_en;

  // R2: an all-ones channel write leaves the converter stopped
  a_r2_off_stops: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_wr && chan_sel == CH_OFF) |=> !busy);

  // R6: 10-bit results never use the top two bits
  a_r6_mid_width: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && conv_mode == RES_MID) |=> (result[RES_W-1:MID_W] == '0));

  // R7: 8-bit results stay in the low byte
  a_r7_low_width: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && conv_mode == RES_LOW) |=> (result[RES_W-1:LOW_W] == '0));

  // R8: the flag only rises from a result write
  a_r8_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(wr_en));

  // R8: masked interrupt stays low
  a_r8_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_en |-> !irq);

  // R10: a failing compare holds the result and does not raise the flag
  a_r10_fail_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_end && !accept) |=> ($stable(result) && !$rose(done_flag)));
endmodule

// File: tb/sar_conv_ctrl_tb.sv
module sar_conv_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_wr = 1'b0;
  logic [4:0]  chan_sel = 5'd0;
  logic [1:0]  res_mode = 2'd2;
  logic        irq_en = 1'b0;
  logic        cmp_en = 1'b0;
  logic        cmp_gt = 1'b0;
  logic [11:0] cmp_thr = 12'd0;
  logic        res_rd = 1'b0;
  logic [11:0] vin = 12'd0;
  logic        cmp_in;
  logic [11:0] dac_code;
  logic        busy;
  logic [11:0] result;
  logic        done_flag;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  assign cmp_in = (vin >= dac_code);

  sar_conv_ctrl #(.CH_W(5)) dut_i (
    .clk(clk), .rst_n(rst_n), .chan_wr(chan_wr), .chan_sel(chan_sel),
    .res_mode(res_mode), .irq_en(irq_en), .cmp_en(cmp_en), .cmp_gt(cmp_gt),
    .cmp_thr(cmp_thr), .cmp_in(cmp_in), .res_rd(res_rd), .dac_code(dac_code),
    .busy(busy), .result(result), .done_flag(done_flag), .irq(irq)
  );

  // {mode, hidden input, expected result}
  localparam logic [25:0] VEC [12] = '{
    {2'd2, 12'hABC, 12'hABC}, {2'd3, 12'hFFF, 12'hFFF},
    {2'd1, 12'h000, 12'h000}, {2'd1, 12'h005, 12'h001},
    {2'd1, 12'h006, 12'h002}, {2'd1, 12'hFFF, 12'h3FF},
    {2'd1, 12'h7FE, 12'h200}, {2'd0, 12'h008, 12'h001},
    {2'd0, 12'h007, 12'h000}, {2'd0, 12'hFFF, 12'h0FF},
    {2'd0, 12'h123, 12'h012}, {2'd0, 12'h018, 12'h002}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic strobe_chan(input logic [4:0] ch);
    @(negedge clk); chan_sel = ch; chan_wr = 1'b1;
    @(negedge clk); chan_wr = 1'b0;
  endtask

  // start a conversion and count cycles until busy drops
  task automatic run_conv(input logic [11:0] v, input logic [1:0] m, output int cyc,
                          output logic [11:0] first_dac, output logic low_bits_used);
    vin = v; res_mode = m;
    strobe_chan(5'd3);
    first_dac = dac_code;
    low_bits_used = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin
      low_bits_used = low_bits_used | (|dac_code[2:0]);
      @(negedge clk); cyc++;
    end
  endtask

  task automatic pulse_rd();
    @(negedge clk); res_rd = 1'b1;
    @(negedge clk); res_rd = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    int cyc;
    logic [11:0] fd;
    logic lb;
    logic [11:0] keep;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0); chk("R1 flag", done_flag, 0); chk("R1 irq", irq, 0);
    chk("R1 result", result, 0); chk("R1 dac", dac_code, 0);
    rst_n = 1'b1;
    irq_en = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] m;
      string rtag;
      m = VEC[i][25:24];
      rtag = (m == 2'd0) ? "R7" : (m == 2'd1) ? "R6" : "R5";
      run_conv(VEC[i][23:12], m, cyc, fd, lb);
      chk("R3 cycles", cyc, (m == 2'd0) ? 9 : 12);
      chk("R3 first trial", fd, 12'h800);
      if (m == 2'd0) chk("R7 low dac bits", lb, 0);
      chk({rtag, " result"}, result, VEC[i][11:0]);
      chk("R8 flag", done_flag, 1);
      chk("R8 irq", irq, 1);
      pulse_rd();
      chk("R9 read clears", done_flag, 0);
    end

    // R4 idle quiet
    repeat (4) begin @(negedge clk); chk("R4 idle dac", dac_code, 0); end

    // R8 masked interrupt
    irq_en = 1'b0;
    run_conv(12'h321, 2'd2, cyc, fd, lb);
    chk("R8 flag masked", done_flag, 1);
    chk("R8 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk("R8 irq unmasked", irq, 1);

    // R2 disable from idle: nothing starts, flag and result kept
    strobe_chan(5'h1F);
    chk("R2 off no busy", busy, 0);
    repeat (14) @(negedge clk);
    chk("R2 off result", result, 12'h321);
    chk("R2 off flag", done_flag, 1);

    // R9 start clears flag
    vin = 12'h555; res_mode = 2'd2;
    strobe_chan(5'd1);
    chk("R9 start clears", done_flag, 0);
    repeat (4) @(negedge clk);
    // R11 restart mid-conversion
    vin = 12'h2AA;
    strobe_chan(5'd2);
    chk("R11 restart trial", dac_code, 12'h800);
    cyc = 0;
    while (busy && cyc < 40) begin @(negedge clk); cyc++; end
    chk("R11 restart cycles", cyc, 12);
    chk("R11 restart result", result, 12'h2AA);

    // R2 abort a running conversion with the off code
    vin = 12'h111;
    strobe_chan(5'd4);
    repeat (3) @(negedge clk);
    strobe_chan(5'h1F);
    chk("R2 abort busy", busy, 0);
    repeat (15) @(negedge clk);
    chk("R2 abort result", result, 12'h2AA);
    chk("R2 abort flag", done_flag, 0);

    // R10 compare
    cmp_en = 1'b1; cmp_gt = 1'b1; cmp_thr = 12'h800;
    run_conv(12'h900, 2'd2, cyc, fd, lb);
    chk("R10 ge pass result", result, 12'h900);
    chk("R10 ge pass flag", done_flag, 1);
    run_conv(12'h100, 2'd2, cyc, fd, lb);
    chk("R10 ge fail result", result, 12'h900);
    chk("R10 ge fail flag", done_flag, 0);
    chk("R10 ge fail irq", irq, 0);
    cmp_gt = 1'b0;
    run_conv(12'h100, 2'd2, cyc, fd, lb);
    chk("R10 lt pass result", result, 12'h100);
    chk("R10 lt pass flag", done_flag, 1);
    cmp_gt = 1'b1; cmp_thr = 12'h040;
    run_conv(12'hFFF, 2'd0, cyc, fd, lb);
    chk("R10 low mode pass", result, 12'h0FF);
    cmp_thr = 12'h3F0;
    run_conv(12'h400, 2'd1, cyc, fd, lb);
    chk("R10 mid mode fail result", result, 12'h0FF);
    chk("R10 mid mode fail flag", done_flag, 0);
    cmp_en = 1'b0;

    keep = result;
    @(negedge clk);
    chk("R4 idle after compare", dac_code, 0);
    chk("R10 result kept", result, keep);
    report();
  end
endmodule